// File: doc/BRIEF.md
# DMA Channel Interrupt and MSI Unit

This unit keeps the interrupt state of one direction of one DMA channel. The channel engine hands it two kinds of single-cycle event pulses: a stop pulse when a transfer finishes and an abort pulse when it fails. Each kind is latched into its own pending bit, which stays set until software writes a one to the matching position of a write-one-to-clear register.

Two notification paths hang off the pending bits. A level interrupt line serves a host sitting next to the engine; it is driven by every pending source that is both passed by its mask bit and locally enabled. When the engine sits far from its host, a remote enable per source lets the unit send a message-signalled interrupt instead: one 32-bit memory write whose 64-bit target address depends on the source (stop and abort each have their own), while both share a single message data word. The write leaves over a valid/ready handshake and is issued once for each rising edge of the source's remote condition.

Software reaches the unit through a small word-indexed register port with a combinational read path.

Top module: `chan_irq_msi`

## Requirements
- R1: A stop pulse sets pending bit 0 and an abort pulse sets pending bit 1; the status register (index 1) returns these two bits in positions 0 and 1 with zeros above, and a set bit stays set with no further events until it is cleared.
- R2: A write to the clear register (index 2) clears the stop pending bit where write data bit 0 is 1 and the abort pending bit where bit 1 is 1; a zero in either position leaves that bit unchanged, and the clear register reads back as zero.
- R3: When an event pulse and a clear of the same pending bit arrive in the same cycle, the bit is set after that cycle.
- R4: The setup register (index 0) holds stop pass (bit 0), abort pass (bit 1), stop local enable (bit 2), abort local enable (bit 3), stop remote enable (bit 4), abort remote enable (bit 5) and remote placement (bit 8); it reads back these bits with all other bits zero. A pass bit of 1 lets its source through.
- R5: The local interrupt output is high exactly when some source is pending, passed and locally enabled, whatever the placement bit; it rises in the cycle after the event edge.
- R6: A message write is requested for a source on each rising edge of (pending AND passed AND remote enable AND placement); with placement at 0 no message write is ever requested.
- R7: A stop message targets the 64-bit address made from index 4 (upper half) and index 3 (lower half); an abort message targets index 6 (upper) and index 5 (lower); both carry the data word at index 7. All five registers read back what was written.
- R8: While the message valid output is high and ready is low, valid, address and data hold steady; one accepted message per rising edge, with no repeat while the condition stays high.
- R9: When both sources rise in the same cycle, the stop message is issued first and the abort message follows after the stop message is accepted.
- R10: After reset all registers and pending bits read zero, the local interrupt is low and no message write is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stop_i | input | 1 | Stop (done) event pulse from the channel engine |
| evt_abort_i | input | 1 | Abort event pulse from the channel engine |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Register word index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_idx_i |
| irq_local_o | output | 1 | Level interrupt to the local host |
| msi_valid_o | output | 1 | Message write offered |
| msi_ready_i | input | 1 | Message write accepted when high with valid |
| msi_addr_o | output | 64 | Message write target address |
| msi_data_o | output | 32 | Message write data |

## Verification
Every cycle the assertions check that an event always leaves its pending bit set even against a simultaneous clear, that a clear without an event drops the bit, that a pending bit holds on its own, that the local line is never high with nothing pending, that an offered message holds address and data until accepted, and that a message is only launched in remote placement. Which address a message carries, the stop-before-abort order, the single message per rising edge, the reset contents and the register readback can only be shown by the bench's scenarios, which compare the ports against values worked out from the requirements.

// File: rtl/irq_msi_pkg.sv
package irq_msi_pkg;

    localparam int WORD_W     = 32;
    localparam int MSI_AW     = 2 * WORD_W;
    localparam int NSRC       = 2;
    localparam int IDX_W      = 3;
    localparam int SRC_STOP   = 0;
    localparam int SRC_ABORT  = 1;
    localparam int REMOTE_BIT = 8;
    localparam int SRC_W      = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef enum logic [IDX_W-1:0] {
        IDX_SETUP   = 3'd0,
        IDX_STATUS  = 3'd1,
        IDX_CLEAR   = 3'd2,
        IDX_STOP_LO = 3'd3,
        IDX_STOP_HI = 3'd4,
        IDX_ABT_LO  = 3'd5,
        IDX_ABT_HI  = 3'd6,
        IDX_MSGDATA = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic            remote;
        logic [NSRC-1:0] rem_en;
        logic [NSRC-1:0] loc_en;
        logic [NSRC-1:0] pass;
    } setup_t;

    typedef struct packed {
        logic [MSI_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } msi_msg_t;

    function automatic logic [WORD_W-1:0] setup_to_word(setup_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[NSRC-1:0]        = s.pass;
        w[2*NSRC-1:NSRC]   = s.loc_en;
        w[3*NSRC-1:2*NSRC] = s.rem_en;
        w[REMOTE_BIT]      = s.remote;
        return w;
    endfunction

    function automatic setup_t word_to_setup(logic [WORD_W-1:0] w);
        setup_t s;
        s.pass   = w[NSRC-1:0];
        s.loc_en = w[2*NSRC-1:NSRC];
        s.rem_en = w[3*NSRC-1:2*NSRC];
        s.remote = w[REMOTE_BIT];
        return s;
    endfunction

    // Lowest index wins: stop is served before abort.
    function automatic logic [SRC_W-1:0] first_set(logic [NSRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

    // Word index of the lower address half for a source.
    function automatic logic [IDX_W-1:0] addr_lo_idx(int src);
        return IDX_W'(int'(IDX_STOP_LO) + 2 * src);
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_msi_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  logic [WORD_W-1:0]             wdata,
    input  logic [NSRC-1:0]               pend,
    output setup_t                        setup,
    output logic [NSRC-1:0]               clr,
    output logic [NSRC-1:0][MSI_AW-1:0]   addr_tab,
    output logic [WORD_W-1:0]             msg_data,
    output logic [WORD_W-1:0]             rdata
);

    setup_t                              setup_q;
    logic [NSRC-1:0][1:0][WORD_W-1:0]    addr_q;
    logic [WORD_W-1:0]                   data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
            data_q  <= '0;
        end else if (wr_en) begin
            if (idx == IDX_SETUP)   setup_q <= word_to_setup(wdata);
            if (idx == IDX_MSGDATA) data_q  <= wdata;
        end
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_addr
        localparam logic [IDX_W-1:0] LO_IDX = addr_lo_idx(k);
        localparam logic [IDX_W-1:0] HI_IDX = LO_IDX + IDX_W'(1);
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[k] <= '0;
            end else if (wr_en) begin
                if (idx == LO_IDX) addr_q[k][0] <= wdata;
                if (idx == HI_IDX) addr_q[k][1] <= wdata;
            end
        end
        assign addr_tab[k] = {addr_q[k][1], addr_q[k][0]};
    end

    assign clr      = (wr_en && idx == IDX_CLEAR) ? wdata[NSRC-1:0] : '0;
    assign setup    = setup_q;
    assign msg_data = data_q;

    always_comb begin
        rdata = '0;
        case (idx)
            IDX_SETUP:   rdata = setup_to_word(setup_q);
            IDX_STATUS:  rdata[NSRC-1:0] = pend;
            IDX_CLEAR:   rdata = '0;
            IDX_STOP_LO: rdata = addr_q[SRC_STOP][0];
            IDX_STOP_HI: rdata = addr_q[SRC_STOP][1];
            IDX_ABT_LO:  rdata = addr_q[SRC_ABORT][0];
            IDX_ABT_HI:  rdata = addr_q[SRC_ABORT][1];
            IDX_MSGDATA: rdata = data_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
    import irq_msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  evt,
    input  logic [NSRC-1:0]  clr,
    output logic [NSRC-1:0]  pend
);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= evt[k] | (bit_q & ~clr[k]);
        end
        assign pend[k] = bit_q;
    end

endmodule

// File: rtl/msi_issuer.sv
module msi_issuer
    import irq_msi_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NSRC-1:0]               fire,
    input  logic [NSRC-1:0][MSI_AW-1:0]   addr_tab,
    input  logic [WORD_W-1:0]             msg_data,
    input  logic                          ready,
    output logic                          valid,
    output msi_msg_t                      msg
);

    logic [NSRC-1:0]  prev_q;
    logic [NSRC-1:0]  req_q;
    logic [NSRC-1:0]  rise;
    logic [NSRC-1:0]  want;
    logic [NSRC-1:0]  taken;
    logic [SRC_W-1:0] pick;
    logic             valid_q;
    logic             launch;
    msi_msg_t         msg_q;

    for (genvar k = 0; k < NSRC; k++) begin : g_edge
        assign rise[k] = fire[k] & ~prev_q[k];
    end

    assign want   = req_q | rise;
    assign pick   = first_set(want);
    assign launch = !valid_q && (|want);
    assign taken  = launch ? (NSRC'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            req_q   <= '0;
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else begin
            prev_q <= fire;
            req_q  <= want & ~taken;
            if (valid_q && ready) begin
                valid_q <= 1'b0;
            end else if (launch) begin
                valid_q    <= 1'b1;
                msg_q.addr <= addr_tab[pick];
                msg_q.data <= msg_data;
            end
        end
    end

    assign valid = valid_q;
    assign msg   = msg_q;

endmodule

// File: rtl/chan_irq_msi.sv
module chan_irq_msi
    import irq_msi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_stop_i,
    input  logic               evt_abort_i,
    input  logic               cfg_wr_i,
    input  logic [2:0]         cfg_idx_i,
    input  logic [31:0]        cfg_wdata_i,
    output logic [31:0]        cfg_rdata_o,
    output logic               irq_local_o,
    output logic               msi_valid_o,
    input  logic               msi_ready_i,
    output logic [63:0]        msi_addr_o,
    output logic [31:0]        msi_data_o
);

    setup_t                        setup;
    logic [NSRC-1:0]               evt;
    logic [NSRC-1:0]               clr;
    logic [NSRC-1:0]               pend;
    logic [NSRC-1:0]               fire;
    logic [NSRC-1:0]               passed;
    logic [NSRC-1:0][MSI_AW-1:0]   addr_tab;
    logic [WORD_W-1:0]             msg_data;
    logic                          remote_mode;
    msi_msg_t                      msg;

    assign evt[SRC_STOP]  = evt_stop_i;
    assign evt[SRC_ABORT] = evt_abort_i;

    irq_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_i),
        .idx      (cfg_idx_i),
        .wdata    (cfg_wdata_i),
        .pend     (pend),
        .setup    (setup),
        .clr      (clr),
        .addr_tab (addr_tab),
        .msg_data (msg_data),
        .rdata    (cfg_rdata_o)
    );

    irq_pend_latch u_pend (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (clr),
        .pend (pend)
    );

    assign remote_mode = setup.remote;
    assign passed      = pend & setup.pass;
    assign irq_local_o = |(passed & setup.loc_en);
    assign fire        = passed & setup.rem_en & {NSRC{remote_mode}};

    msi_issuer u_msi (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .addr_tab (addr_tab),
        .msg_data (msg_data),
        .ready    (msi_ready_i),
        .valid    (msi_valid_o),
        .msg      (msg)
    );

    assign msi_addr_o = msg.addr;
    assign msi_data_o = msg.data;

endmodule

// File: rtl/chan_irq_msi_chk.sv
module chan_irq_msi_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  evt,
    input logic [1:0]  clr,
    input logic [1:0]  pend,
    input logic        remote,
    input logic        irq_local,
    input logic        valid,
    input logic        ready,
    input logic [63:0] addr,
    input logic [31:0] data
);

    AST_STOP_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt[0] |=> pend[0]); // R3

    AST_ABORT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt[1] |=> pend[1]); // R3

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr[0] && !evt[0]) |=> !pend[0]); // R2

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend[1] && !clr[1]) |=> pend[1]); // R1

    AST_LOCAL_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_local |-> (|pend)); // R5

    AST_MSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(data))); // R8

    AST_MSI_REMOTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(remote)); // R6

endmodule

bind chan_irq_msi chan_irq_msi_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .clr       (clr),
    .pend      (pend),
    .remote    (remote_mode),
    .irq_local (irq_local_o),
    .valid     (msi_valid_o),
    .ready     (msi_ready_i),
    .addr      (msi_addr_o),
    .data      (msi_data_o)
);

// File: tb/sim_chan_irq_msi.sv
`timescale 1ns/1ps
module sim_chan_irq_msi;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_stop = 1'b0;
    logic        evt_abort = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_local;
    logic        msi_valid;
    logic        msi_ready = 1'b0;
    logic [63:0] msi_addr;
    logic [31:0] msi_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [63:0] STOP_ADDR  = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] ABORT_ADDR = 64'h0BAD_F00D_0000_1000;
    localparam logic [31:0] MSG_WORD   = 32'hCAFE_0042;

    always #2 clk = ~clk;

    chan_irq_msi u0 (
        .clk         (clk),
        .rst         (rst),
        .evt_stop_i  (evt_stop),
        .evt_abort_i (evt_abort),
        .cfg_wr_i    (cfg_wr),
        .cfg_idx_i   (cfg_idx),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .irq_local_o (irq_local),
        .msi_valid_o (msi_valid),
        .msi_ready_i (msi_ready),
        .msi_addr_o  (msi_addr),
        .msi_data_o  (msi_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        cfg_idx = idx;
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic pulse(input logic s, input logic a);
        @(negedge clk);
        evt_stop = s; evt_abort = a;
        @(negedge clk);
        evt_stop = 1'b0; evt_abort = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (msi_valid) got = 1;
        end
    endtask

    task automatic accept();
        @(negedge clk);
        msi_ready = 1'b1;
        @(negedge clk);
        msi_ready = 1'b0;
    endtask

    task automatic quiet(input string tag);
        bit got;
        wait_valid(got);
        chk(tag, {63'd0, got}, 64'd0);
    endtask

    task automatic clean();
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h3);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            chk($sformatf("R10 reg %0d after reset", i), {32'd0, d}, 64'd0);
        end
        chk("R10 irq_local after reset", {63'd0, irq_local}, 64'd0);
        chk("R10 msi_valid after reset", {63'd0, msi_valid}, 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d);
        chk("R4 setup readback", {32'd0, d}, 64'h13F);
        wr(3'd0, 32'h0000_0105);
        rd(3'd0, d);
        chk("R4 setup partial readback", {32'd0, d}, 64'h105);
        wr(3'd3, STOP_ADDR[31:0]);
        wr(3'd4, STOP_ADDR[63:32]);
        wr(3'd5, ABORT_ADDR[31:0]);
        wr(3'd6, ABORT_ADDR[63:32]);
        wr(3'd7, MSG_WORD);
        rd(3'd3, d); chk("R7 stop lo", {32'd0, d}, {32'd0, STOP_ADDR[31:0]});
        rd(3'd4, d); chk("R7 stop hi", {32'd0, d}, {32'd0, STOP_ADDR[63:32]});
        rd(3'd5, d); chk("R7 abort lo", {32'd0, d}, {32'd0, ABORT_ADDR[31:0]});
        rd(3'd6, d); chk("R7 abort hi", {32'd0, d}, {32'd0, ABORT_ADDR[63:32]});
        rd(3'd7, d); chk("R7 msg data", {32'd0, d}, {32'd0, MSG_WORD});
        wr(3'd0, 32'h0);
    endtask

    task automatic t_status_clear();
        logic [31:0] d;
        pulse(1, 0);
        rd(3'd1, d); chk("R1 stop pending", {32'd0, d}, 64'h1);
        pulse(0, 1);
        repeat (4) @(negedge clk);
        rd(3'd1, d); chk("R1 both pending held", {32'd0, d}, 64'h3);
        rd(3'd2, d); chk("R2 clear reads zero", {32'd0, d}, 64'h0);
        wr(3'd2, 32'h0);
        rd(3'd1, d); chk("R2 zero clear no effect", {32'd0, d}, 64'h3);
        wr(3'd2, 32'h2);
        rd(3'd1, d); chk("R2 abort clear only", {32'd0, d}, 64'h1);
        wr(3'd2, 32'h1);
        rd(3'd1, d); chk("R2 stop clear", {32'd0, d}, 64'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        evt_stop = 1'b1; cfg_wr = 1'b1; cfg_idx = 3'd2; cfg_wdata = 32'h1;
        @(negedge clk);
        evt_stop = 1'b0; cfg_wr = 1'b0;
        rd(3'd1, d); chk("R3 set beats clear", {32'd0, d}, 64'h1);
        clean();
    endtask

    task automatic t_local();
        wr(3'd0, 32'h0000_0004);
        pulse(1, 0);
        chk("R5 masked stop no local irq", {63'd0, irq_local}, 64'd0);
        wr(3'd0, 32'h0000_0005);
        chk("R5 unmasked local irq", {63'd0, irq_local}, 64'd1);
        wr(3'd0, 32'h0000_0001);
        chk("R5 local enable off", {63'd0, irq_local}, 64'd0);
        clean();
        wr(3'd0, 32'h0000_010A);
        pulse(0, 1);
        chk("R5 abort local irq in remote placement", {63'd0, irq_local}, 64'd1);
        wr(3'd2, 32'h2);
        chk("R5 local irq drops on clear", {63'd0, irq_local}, 64'd0);
        clean();
    endtask

    task automatic t_no_remote();
        wr(3'd0, 32'h0000_0033);
        pulse(1, 1);
        quiet("R6 no message without remote placement");
        clean();
    endtask

    task automatic t_msi_stop_hold();
        bit got;
        wr(3'd0, 32'h0000_0111);
        pulse(1, 0);
        wait_valid(got);
        chk("R6 stop message offered", {63'd0, got}, 64'd1);
        chk("R7 stop message address", msi_addr, STOP_ADDR);
        chk("R7 stop message data", {32'd0, msi_data}, {32'd0, MSG_WORD});
        repeat (3) @(negedge clk);
        chk("R8 valid held without ready", {63'd0, msi_valid}, 64'd1);
        chk("R8 address held without ready", msi_addr, STOP_ADDR);
        accept();
        chk("R8 valid drops after accept", {63'd0, msi_valid}, 64'd0);
        quiet("R8 no repeat while level high");
        wr(3'd2, 32'h1);
        pulse(1, 0);
        wait_valid(got);
        chk("R6 new message on next rise", {63'd0, got}, 64'd1);
        accept();
        clean();
    endtask

    task automatic t_order();
        bit got;
        wr(3'd0, 32'h0000_0133);
        pulse(1, 1);
        wait_valid(got);
        chk("R9 first message present", {63'd0, got}, 64'd1);
        chk("R9 stop first", msi_addr, STOP_ADDR);
        accept();
        wait_valid(got);
        chk("R9 second message present", {63'd0, got}, 64'd1);
        chk("R9 abort second", msi_addr, ABORT_ADDR);
        chk("R7 abort message data", {32'd0, msi_data}, {32'd0, MSG_WORD});
        accept();
        quiet("R9 only two messages");
        clean();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_status_clear();
        t_set_wins();
        t_local();
        t_no_remote();
        t_msi_stop_hold();
        t_order();
        finish_run();
    end

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule